// File: doc/BRIEF.md
# Four-Source Interrupt Controller with Stack-Full Gating

This block collects interrupt requests for a small 8-bit processor core from four sources: a falling edge on an external pin, and single-cycle event pulses from a timer/event counter, a time base and a real-time clock. Every request sets a sticky flag, whether or not the source is enabled and whether or not interrupts are globally allowed. Software reads and writes two 8-bit control registers. Together they hold the global enable, one enable per source and one request flag per source.

When the global enable is set, at least one source is both enabled and flagged, the core reports that it sits at an instruction boundary, and the return stack is not full, the controller issues a one-cycle acknowledge with a 2-bit vector index. The index picks the pending source under a fixed priority. In the same cycle the controller clears the global enable and the flag of the serviced source. Further interrupts therefore stay blocked until the service routine sets the global enable again, which is how nesting is allowed. Saving the processor status is left to software.

Top module: `irq_ctrl`

## Requirements
- R1: After reset both control registers read 0x00 and `irq_ack` is 0.
- R2: Control register 0 (`reg_sel`=0) holds the global enable in bit 0, the external and timer enables in bits 1 and 2, and the external and timer flags in bits 4 and 5. Control register 1 (`reg_sel`=1) holds the time-base and real-time-clock enables in bits 1 and 2 and their flags in bits 4 and 5. A write takes effect at the next clock edge, and all other bits read 0.
- R3: A falling edge on `ext_pin` sets the external flag after the pin has passed a two-stage synchronizer. A rising edge sets nothing.
- R4: A one-cycle pulse on `tmr_evt`, `tbase_evt` or `rtc_evt` sets the matching flag, even while the source is disabled or the global enable is clear. The flag stays set until it is serviced or written.
- R5: `irq_ack` is a single-cycle pulse. It rises only after a clock edge at which the global enable was 1, `core_ready` was 1, `stack_full` was 0, and at least one source had both its enable and its flag set.
- R6: When several sources are pending, `irq_vec` names the highest-priority one. The encoding is 0 external, 1 timer, 2 time base, 3 real-time clock, and a lower value has priority.
- R7: On acknowledge the global enable and the serviced source's flag clear, and every other flag and enable keeps its value.
- R8: While `stack_full` is 1, no acknowledge is issued. Once it drops, a still-pending request is acknowledged.
- R9: After an acknowledge, a software write that sets the global enable again lets the next pending source be acknowledged (nesting).
- R10: If a source's event arrives in the same cycle as that source is acknowledged, its flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin, active on falling edge |
| tmr_evt | input | 1 | Timer/event counter request pulse |
| tbase_evt | input | 1 | Time-base request pulse |
| rtc_evt | input | 1 | Real-time-clock request pulse |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 1 | Control register select (0 or 1) |
| reg_wdata | input | 8 | Control register write data |
| ctl0_q | output | 8 | Control register 0 contents |
| ctl1_q | output | 8 | Control register 1 contents |
| core_ready | input | 1 | Core is at an instruction boundary and can take an interrupt |
| stack_full | input | 1 | Return stack is full |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| irq_vec | output | 2 | Vector index of the acknowledged source |

## Verification
The bench builds the block with its default parameters: four sources split two per register and a two-stage pin synchronizer. At that size it can sweep all 256 combinations of flag and enable patterns, and for each one it works out the expected vector, the acknowledge and the register contents that remain after the acknowledge. Directed sequences then cover the pin edge polarity, events that arrive while interrupts are masked, stack-full blocking and release, re-enabling for nesting, and an event that collides with the acknowledge of the same source.

// File: rtl/irq_pkg.sv
// Package: shared sizes and control-register field positions for the
// interrupt controller. Assumes sources are spread evenly over registers.
package irq_pkg;
    localparam int NUM_SRC     = 4;
    localparam int SRC_PER_REG = 2;
    localparam int NUM_REG     = NUM_SRC / SRC_PER_REG;
    localparam int DATA_W      = 8;
    localparam int SEL_W       = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;
    localparam int VEC_W       = $clog2(NUM_SRC);
    localparam int GIE_BIT     = 0;
    localparam int EN_LSB      = 1;
    localparam int FLAG_LSB    = 4;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [VEC_W-1:0] {
        SRC_EXT   = 2'd0,
        SRC_TMR   = 2'd1,
        SRC_TBASE = 2'd2,
        SRC_RTC   = 2'd3
    } src_e;
endpackage

// File: rtl/irq_fall_detect.sv
// Module: synchronizes an asynchronous pin and flags each falling edge
// as a one-cycle pulse. Assumes STAGES >= 2; the chain resets low so a
// pin idling high after reset produces no edge.
module irq_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchronizer and keep the last stable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A high-to-low step of the synchronized level is a falling edge.
    always_comb fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/irq_arbiter.sv
// Module: fixed-priority picker; the lowest-numbered pending source wins.
// Purely combinational; assumes the caller qualifies 'any'.
module irq_arbiter #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Walk from lowest to highest priority so the highest one is kept last.
    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_regs.sv
// Module: the two software control registers. Holds the global enable,
// per-source enables and sticky per-source flags. Flag update order:
// software write, then acknowledge clear, then hardware set (set wins).
module irq_regs
    import irq_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [NUM_SRC-1:0]               set_req,
    input  logic [NUM_SRC-1:0]               clr_req,
    input  logic                             clr_gie,
    output logic                             gie_o,
    output logic [NUM_SRC-1:0]               en_o,
    output logic [NUM_SRC-1:0]               flag_o,
    output logic [NUM_REG-1:0][DATA_W-1:0]   rd_o
);
    localparam logic [DATA_W-1:0] USED_MASK =
        DATA_W'(((1 << SRC_PER_REG) - 1) << EN_LSB) |
        DATA_W'(((1 << SRC_PER_REG) - 1) << FLAG_LSB) |
        DATA_W'(1 << GIE_BIT);

    logic gie_q;
    logic unused_wdata;

    // Global enable: the acknowledge clear overrides a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_q <= 1'b0;
        else if (clr_gie)
            gie_q <= 1'b0;
        else if (wr_en && wr_sel == SEL_W'(0))
            gie_q <= wr_data[GIE_BIT];
    end

    assign gie_o        = gie_q;
    assign unused_wdata = ^(wr_data & ~USED_MASK);

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        localparam int BASE = r * SRC_PER_REG;
        logic [SRC_PER_REG-1:0] en_q;
        logic [SRC_PER_REG-1:0] fl_q;
        logic                   hit;

        assign hit = wr_en && (wr_sel == SEL_W'(r));

        // Per-register enables and flags with write, clear and set merging.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= '0;
                fl_q <= '0;
            end else begin
                for (int s = 0; s < SRC_PER_REG; s++) begin
                    if (hit) en_q[s] <= wr_data[EN_LSB + s];
                    fl_q[s] <= ((hit ? wr_data[FLAG_LSB + s] : fl_q[s])
                                & ~clr_req[BASE + s]) | set_req[BASE + s];
                end
            end
        end

        assign en_o[BASE +: SRC_PER_REG]   = en_q;
        assign flag_o[BASE +: SRC_PER_REG] = fl_q;

        // Assemble the read view; unassigned bits read zero.
        always_comb begin
            rd_o[r] = '0;
            for (int s = 0; s < SRC_PER_REG; s++) begin
                rd_o[r][EN_LSB + s]   = en_q[s];
                rd_o[r][FLAG_LSB + s] = fl_q[s];
            end
            if (r == 0) rd_o[r][GIE_BIT] = gie_q;
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
// Module: top of the interrupt controller. Gathers the four request
// sources, qualifies pending ones with enables and the global enable,
// and acknowledges the highest-priority one when the core is at an
// instruction boundary and the return stack has room. Assumes the event
// inputs are synchronous one-cycle pulses and ext_pin is asynchronous.
module irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              tmr_evt,
    input  logic              tbase_evt,
    input  logic              rtc_evt,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] ctl0_q,
    output logic [DATA_W-1:0] ctl1_q,
    input  logic              core_ready,
    input  logic              stack_full,
    output logic              irq_ack,
    output logic [VEC_W-1:0]  irq_vec
);
    logic                           ext_fall;
    logic [NUM_SRC-1:0]             set_req;
    logic [NUM_SRC-1:0]             clr_req;
    logic [NUM_SRC-1:0]             en;
    logic [NUM_SRC-1:0]             flag;
    logic [NUM_SRC-1:0]             pend;
    logic                           gie;
    logic                           any_pend;
    logic [VEC_W-1:0]               win_idx;
    logic                           take;
    logic [NUM_REG-1:0][DATA_W-1:0] rd;
    logic                           ack_q;
    logic [VEC_W-1:0]               vec_q;

    irq_fall_detect #(.STAGES(SYNC_STAGES)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .fall  (ext_fall)
    );

    // Hardware request vector in priority order.
    always_comb begin
        set_req            = '0;
        set_req[SRC_EXT]   = ext_fall;
        set_req[SRC_TMR]   = tmr_evt;
        set_req[SRC_TBASE] = tbase_evt;
        set_req[SRC_RTC]   = rtc_evt;
    end

    irq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (SEL_W'(reg_sel)),
        .wr_data (reg_wdata),
        .set_req (set_req),
        .clr_req (clr_req),
        .clr_gie (take),
        .gie_o   (gie),
        .en_o    (en),
        .flag_o  (flag),
        .rd_o    (rd)
    );

    // A source is pending only when flagged, enabled and globally allowed.
    always_comb pend = flag & en & {NUM_SRC{gie}};

    irq_arbiter #(.N(NUM_SRC)) u_arb (
        .pend (pend),
        .any  (any_pend),
        .idx  (win_idx)
    );

    // Take an interrupt only at an instruction boundary with stack room.
    always_comb begin
        take    = any_pend && core_ready && !stack_full;
        clr_req = take ? (NUM_SRC'(1) << win_idx) : '0;
    end

    // Register the acknowledge pulse and the vector that goes with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            vec_q <= '0;
        end else begin
            ack_q <= take;
            if (take) vec_q <= win_idx;
        end
    end

    assign irq_ack = ack_q;
    assign irq_vec = vec_q;
    assign ctl0_q  = rd[0];
    assign ctl1_q  = rd[1];
endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: property checker for irq_ctrl, attached by bind. Observes only
// the top-level ports and recomputes the pending set from the register view.
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ctl0_q,
    input logic [DATA_W-1:0] ctl1_q,
    input logic              core_ready,
    input logic              stack_full,
    input logic              irq_ack,
    input logic [VEC_W-1:0]  irq_vec
);
    logic [NUM_SRC-1:0] pend_now;
    logic [NUM_SRC-1:0] pend_q;
    logic               gie_now;

    // Pending set as seen through the register view.
    always_comb begin
        gie_now  = ctl0_q[GIE_BIT];
        pend_now = {ctl1_q[FLAG_LSB+1] & ctl1_q[EN_LSB+1],
                    ctl1_q[FLAG_LSB]   & ctl1_q[EN_LSB],
                    ctl0_q[FLAG_LSB+1] & ctl0_q[EN_LSB+1],
                    ctl0_q[FLAG_LSB]   & ctl0_q[EN_LSB]} & {NUM_SRC{gie_now}};
    end

    // Remember the previous cycle's pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_now;
    end

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);
    p_ack_needs_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_now |=> !irq_ack);
    p_ack_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(core_ready));
    p_no_ack_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stack_full |=> !irq_ack);
    p_vec_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> pend_q[irq_vec]);
    p_vec_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ((pend_q & ((NUM_SRC'(1) << irq_vec) - NUM_SRC'(1))) == '0));
    p_gie_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !gie_now);
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0_q[7:6] == 2'b0) && !ctl0_q[3] && (ctl1_q[7:6] == 2'b0)
        && !ctl1_q[3] && !ctl1_q[0]);
endmodule

bind irq_ctrl irq_ctrl_chk u_irq_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl0_q     (ctl0_q),
    .ctl1_q     (ctl1_q),
    .core_ready (core_ready),
    .stack_full (stack_full),
    .irq_ack    (irq_ack),
    .irq_vec    (irq_vec)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b1;
    logic       tmr_evt = 1'b0, tbase_evt = 1'b0, rtc_evt = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctl0_q, ctl1_q;
    logic       core_ready = 1'b0, stack_full = 1'b0;
    logic       irq_ack;
    logic [1:0] irq_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_evt(tmr_evt),
        .tbase_evt(tbase_evt), .rtc_evt(rtc_evt), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ctl0_q(ctl0_q),
        .ctl1_q(ctl1_q), .core_ready(core_ready), .stack_full(stack_full),
        .irq_ack(irq_ack), .irq_vec(irq_vec)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Write a register; returns at the negedge after the write edge.
    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] mk0(input logic [3:0] fl, input logic [3:0] en, input logic g);
        return {2'b00, fl[1:0], 1'b0, en[1:0], g};
    endfunction

    function automatic logic [7:0] mk1(input logic [3:0] fl, input logic [3:0] en);
        return {2'b00, fl[3:2], 1'b0, en[3:2], 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ctl0", ctl0_q, 8'h00);
        chk("R1 ctl1", ctl1_q, 8'h00);
        chk("R1 ack", irq_ack, 0);

        // R2: field layout and unused bits
        wr(1'b0, 8'hFF);
        chk("R2 ctl0 readback", ctl0_q, 8'h37);
        wr(1'b1, 8'hFF);
        chk("R2 ctl1 readback", ctl1_q, 8'h36);
        chk("R2 no ack without ready", irq_ack, 0);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        chk("R2 cleared", {ctl1_q, ctl0_q}, 16'h0000);

        // R5 R6 R7: sweep all flag and enable patterns
        for (int p = 0; p < 256; p++) begin
            logic [3:0] fl, en, pend, left;
            int v;
            fl = p[3:0]; en = p[7:4];
            pend = fl & en;
            v = 0;
            for (int i = 3; i >= 0; i--) if (pend[i]) v = i;
            wr(1'b0, mk0(fl, en, 1'b1));
            wr(1'b1, mk1(fl, en));
            core_ready = 1'b1;
            @(negedge clk);
            core_ready = 1'b0;
            if (pend != 0) begin
                left = fl & ~(4'b1 << v);
                chk("R5 ack on pending", irq_ack, 1);
                chk("R6 vector", irq_vec, v);
                chk("R7 ctl0 after ack", ctl0_q, mk0(left, en, 1'b0));
                chk("R7 ctl1 after ack", ctl1_q, mk1(left, en));
            end else begin
                chk("R5 no ack", irq_ack, 0);
                chk("R5 ctl0 kept", ctl0_q, mk0(fl, en, 1'b1));
                chk("R5 ctl1 kept", ctl1_q, mk1(fl, en));
            end
            @(negedge clk);
            chk("R5 single pulse", irq_ack, 0);
        end
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);

        // R3: falling edge on the pin sets the external flag
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 fall sets flag", ctl0_q[4], 1);
        wr(1'b0, 8'h00);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 rise ignored", ctl0_q[4], 0);

        // R4: masked events still latch; R9-style release by software
        wr(1'b0, 8'h06);
        wr(1'b1, 8'h06);
        core_ready = 1'b1;
        tmr_evt = 1'b1;
        @(negedge clk);
        tmr_evt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 timer flag while masked", ctl0_q, 8'h26);
        chk("R4 no ack while masked", irq_ack, 0);
        rtc_evt = 1'b1;
        @(negedge clk);
        rtc_evt = 1'b0;
        tbase_evt = 1'b1;
        @(negedge clk);
        tbase_evt = 1'b0;
        chk("R4 rtc and tbase flags", ctl1_q, 8'h36);
        core_ready = 1'b0;
        wr(1'b0, 8'h27);
        core_ready = 1'b1;
        @(negedge clk);
        chk("R4 ack after enable", irq_ack, 1);
        chk("R6 timer vector", irq_vec, 1);

        // R9: nesting after software re-enables
        repeat (3) @(negedge clk);
        chk("R9 blocked until re-enable", irq_ack, 0);
        core_ready = 1'b0;
        wr(1'b0, 8'h07);
        core_ready = 1'b1;
        @(negedge clk);
        chk("R9 nested ack", irq_ack, 1);
        chk("R9 nested vector time base", irq_vec, 2);
        core_ready = 1'b0;
        chk("R9 rtc still pending", ctl1_q, 8'h26);

        // R8: stack full blocks, release acknowledges
        wr(1'b0, 8'h37);
        stack_full = 1'b1;
        core_ready = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk("R8 no ack while full", irq_ack, 0);
        end
        chk("R8 state kept while full", ctl0_q, 8'h37);
        stack_full = 1'b0;
        @(negedge clk);
        core_ready = 1'b0;
        chk("R8 ack after release", irq_ack, 1);
        chk("R8 vector external", irq_vec, 0);

        // R10: event colliding with its own acknowledge keeps the flag
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h24);
        wr(1'b0, 8'h01);
        core_ready = 1'b1;
        rtc_evt = 1'b1;
        @(negedge clk);
        rtc_evt = 1'b0;
        core_ready = 1'b0;
        chk("R10 ack rtc", irq_ack, 1);
        chk("R10 vector rtc", irq_vec, 3);
        chk("R10 flag kept", ctl1_q, 8'h24);
        chk("R10 gie cleared", ctl0_q, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule